// File: doc/BRIEF.md
# Pipelined Crossbar Matching Scheduler

This block is the central arbiter of an input-queued crossbar. Every slot, which is one clock cycle here, each of N ingress adapters presents one request bit per output. The arbiter returns a grant matrix whose rows tell each adapter which output it may transmit to in that slot. An output has two receivers, so it can accept up to two inputs in one slot. An input is granted at most one output.

The matching is found by a request-grant-accept heuristic. One iteration runs per pipeline stage, and there are ITER stages. A fresh matching starts in stage 0 every slot. The partial matching in stage k moves to stage k+1 one slot later. Each stage works on the request matrix of the current slot. It drops pairs whose request has gone away, and it adds new pairs only between inputs that are still free and outputs that still have a free receiver. The last stage writes the grant register.

Requests also reach the last stage directly. A request that arrives while the pipeline is idle is therefore granted after one clock edge, so the pipelining adds no latency to the shortest request-to-grant path. Fairness comes from round-robin pointers: one per output for its grant choice and one per input for its accept choice. Only acceptances made in stage 0 move these pointers.

Top module: `xbarMatchSched`

## Requirements
- R1: Grant bit i*N+j set means input i may send to output j in this slot. Request bit i*N+j uses the same layout. Every set grant bit matches a request bit that was set in the cycle before the grant appears.
- R2: Each input row of the grant matrix has at most one bit set.
- R3: Each output column of the grant matrix has at most CAP (default 2) bits set.
- R4: A request presented while the pipeline holds no pairs is granted at the next clock edge, provided no other request competes for it.
- R5: A new matching enters stage 0 every cycle. Stage k+1 keeps every pair from stage k whose request is still present. It adds pairs only among unmatched inputs and outputs with a free receiver. Every pair kept into the last stage is issued as a grant.
- R6: A pair whose request is withdrawn before the last stage is not issued.
- R7: Round-robin order works as follows:
  - An output scans inputs upward from its grant pointer, wrapping round, and grants up to its free receivers.
  - An input scans outputs upward from its accept pointer and accepts the first grant it finds.
  - Only stage-0 acceptances move a pointer. An input pointer moves to one past the accepted output. An output pointer moves to one past the last input it had accepted, in scan order.
- R8: Reset clears the grants, the pipeline stages and all pointers, so all pointers start at index 0.
- R9: Suppose three inputs keep requesting one output for 30 slots. Each of the three inputs is then granted in at least 8 of those slots.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slot clock |
| rstN | input | 1 | Synchronous reset, active low |
| reqMat | input | N*N | Request matrix, bit i*N+j: input i wants output j |
| grantMat | output | N*N | Grant matrix, bit i*N+j: input i is sent to output j |

## Verification
The hardest case to reach is a later stage that both drops pairs and adds new ones. This happens when an in-flight partial matching meets a request matrix that differs from the one it was built on. A bench that only holds steady traffic never produces it. The stimulus therefore changes patterns every few slots, from full load through permutations to sparse sets, and withdraws a held request right after it has reached the pipeline. A cycle-exact reference model of the stages and pointers predicts every grant matrix. Directed cases with hand-worked values cover single requests, output contention and pointer rotation.

// File: rtl/schedPkg.sv
package schedPkg;
  // Advance an index by off positions on a ring of n entries; base and off are below n.
  function automatic int wrapAdd(input int base, input int off, input int n);
    int sum;
    sum = base + off;
    return (sum >= n) ? sum - n : sum;
  endfunction
endpackage

// File: rtl/rgaStage.sv
module rgaStage #(
  parameter int N   = 8,
  parameter int CAP = 2,
  parameter int PW  = 3
) (
  input  logic [N*N-1:0]  reqMat,
  input  logic [N*N-1:0]  inMatch,
  input  logic [N*PW-1:0] gPtr,
  input  logic [N*PW-1:0] aPtr,
  output logic [N*N-1:0]  outMatch
);
  import schedPkg::*;

  logic [N-1:0]   inFree;
  int             spare [N];
  logic [N*N-1:0] elig;
  logic [N*N-1:0] gnt;
  logic [N*N-1:0] acc;

  // Free inputs and spare receivers per output, given the partial matching
  always_comb begin
    for (int i = 0; i < N; i++) inFree[i] = ~|inMatch[i*N +: N];
    for (int j = 0; j < N; j++) begin
      int used;
      used = 0;
      for (int i = 0; i < N; i++) used = used + (inMatch[i*N+j] ? 1 : 0);
      spare[j] = (used >= CAP) ? 0 : CAP - used;
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        elig[i*N+j] = reqMat[i*N+j] & inFree[i] & (spare[j] > 0);
  end

  // Grant phase: each output offers up to its spare count, scanning from its pointer
  always_comb begin
    gnt = '0;
    for (int j = 0; j < N; j++) begin
      int taken;
      taken = 0;
      for (int off = 0; off < N; off++) begin
        int idx;
        idx = wrapAdd(int'(gPtr[j*PW +: PW]), off, N);
        if (elig[idx*N+j] && (taken < spare[j])) begin
          gnt[idx*N+j] = 1'b1;
          taken = taken + 1;
        end
      end
    end
  end

  // Accept phase: each input takes the first offer found from its pointer
  always_comb begin
    acc = '0;
    for (int i = 0; i < N; i++) begin
      logic got;
      got = 1'b0;
      for (int off = 0; off < N; off++) begin
        int idx;
        idx = wrapAdd(int'(aPtr[i*PW +: PW]), off, N);
        if (gnt[i*N+idx] && !got) begin
          acc[i*N+idx] = 1'b1;
          got = 1'b1;
        end
      end
    end
  end

  assign outMatch = inMatch | acc;
endmodule

// File: rtl/schedCtrl.sv
module schedCtrl #(
  parameter int N  = 8,
  parameter int PW = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [N*N-1:0]  firstAcc,
  output logic [N*PW-1:0] gPtr,
  output logic [N*PW-1:0] aPtr
);
  import schedPkg::*;

  logic [PW-1:0] gReg  [N];
  logic [PW-1:0] aReg  [N];
  logic [PW-1:0] gNext [N];
  logic [PW-1:0] aNext [N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      aNext[i] = aReg[i];
      for (int j = 0; j < N; j++)
        if (firstAcc[i*N+j]) aNext[i] = PW'(wrapAdd(j, 1, N));
    end
    for (int j = 0; j < N; j++) begin
      gNext[j] = gReg[j];
      for (int off = 0; off < N; off++) begin
        int idx;
        idx = wrapAdd(int'(gReg[j]), off, N);
        if (firstAcc[idx*N+j]) gNext[j] = PW'(wrapAdd(idx, 1, N));
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < N; k++) begin
      if (!rstN) begin
        gReg[k] <= '0;
        aReg[k] <= '0;
      end else begin
        gReg[k] <= gNext[k];
        aReg[k] <= aNext[k];
      end
    end
  end

  genvar p;
  generate
    for (p = 0; p < N; p++) begin : g_pack
      assign gPtr[p*PW +: PW] = gReg[p];
      assign aPtr[p*PW +: PW] = aReg[p];
    end
  endgenerate

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (firstAcc == '0) |=> ($stable(gPtr) && $stable(aPtr))); // R7
endmodule

// File: rtl/matchPath.sv
module matchPath #(
  parameter int N    = 8,
  parameter int CAP  = 2,
  parameter int ITER = 3,
  parameter int PW   = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [N*N-1:0]  reqMat,
  input  logic [N*PW-1:0] gPtr,
  input  logic [N*PW-1:0] aPtr,
  output logic [N*N-1:0]  firstAcc,
  output logic [N*N-1:0]  grantMat
);
  logic [N*N-1:0] stIn  [ITER];
  logic [N*N-1:0] stOut [ITER];
  logic [N*N-1:0] stReg [ITER];

  genvar k;
  generate
    for (k = 0; k < ITER; k++) begin : g_stage
      if (k == 0) begin : g_head
        assign stIn[k] = '0;
      end else begin : g_tail
        assign stIn[k] = stReg[k-1] & reqMat;
      end
      rgaStage #(.N(N), .CAP(CAP), .PW(PW)) uStage (
        .reqMat  (reqMat),
        .inMatch (stIn[k]),
        .gPtr    (gPtr),
        .aPtr    (aPtr),
        .outMatch(stOut[k])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    for (int s = 0; s < ITER; s++) begin
      if (!rstN) stReg[s] <= '0;
      else       stReg[s] <= stOut[s];
    end
  end

  assign firstAcc = stOut[0];
  assign grantMat = stReg[ITER-1];

  logic [N-1:0] colVec [N];
  genvar c, r;
  generate
    for (c = 0; c < N; c++) begin : g_col
      for (r = 0; r < N; r++) begin : g_bit
        assign colVec[c][r] = grantMat[r*N+c];
      end
      AST_OUT_CAP: assert property (@(posedge clk) disable iff (!rstN)
        $countones(colVec[c]) <= CAP); // R3
      AST_IN_ONE: assert property (@(posedge clk) disable iff (!rstN)
        $onehot0(grantMat[c*N +: N])); // R2
    end
  endgenerate

  AST_GRANT_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (grantMat & ~$past(reqMat)) == '0); // R1
  AST_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stIn[ITER-1]) & ~grantMat) == '0); // R5
endmodule

// File: rtl/xbarMatchSched.sv
module xbarMatchSched #(
  parameter int N    = 8,
  parameter int ITER = 3,
  parameter int CAP  = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [N*N-1:0] reqMat,
  output logic [N*N-1:0] grantMat
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [N*PW-1:0] gPtr;
  logic [N*PW-1:0] aPtr;
  logic [N*N-1:0]  firstAcc;

  schedCtrl #(.N(N), .PW(PW)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .firstAcc(firstAcc),
    .gPtr    (gPtr),
    .aPtr    (aPtr)
  );

  matchPath #(.N(N), .CAP(CAP), .ITER(ITER), .PW(PW)) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .reqMat  (reqMat),
    .gPtr    (gPtr),
    .aPtr    (aPtr),
    .firstAcc(firstAcc),
    .grantMat(grantMat)
  );
endmodule

// File: tb/xbarMatchSched_test.sv
`timescale 1ns/1ps
module xbarMatchSched_test;
  localparam int N   = 8;
  localparam int IT  = 3;
  localparam int CAP = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rstN;
  logic [N*N-1:0] reqMat;
  logic [N*N-1:0] grantMat;

  xbarMatchSched #(.N(N), .ITER(IT), .CAP(CAP)) uut (
    .clk(clk), .rstN(rstN), .reqMat(reqMat), .grantMat(grantMat));

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  logic [N*N-1:0] mSt [IT];
  int gpM [N];
  int apM [N];

  localparam logic [N*N-1:0] PATS [8] = '{
    64'hFFFF_FFFF_FFFF_FFFF, 64'h8040_2010_0804_0201,
    64'h0000_0000_0000_00FF, 64'h0101_0101_0101_0101,
    64'hF0F0_0F0F_F0F0_0F0F, 64'h1234_5678_9ABC_DEF0,
    64'h0303_0303_0303_0303, 64'h0000_0000_0000_0000};

  function automatic int wrapN(input int v);
    return (v >= N) ? v - N : v;
  endfunction

  function automatic logic [N*N-1:0] bitAt(input int i, input int j);
    logic [N*N-1:0] v;
    v = '0;
    v[i*N+j] = 1'b1;
    return v;
  endfunction

  // One request-grant-accept round of the reference model
  function automatic logic [N*N-1:0] refIter(input logic [N*N-1:0] req,
                                             input logic [N*N-1:0] part);
    logic [N-1:0]   busy;
    int             room [N];
    logic [N*N-1:0] offer;
    logic [N*N-1:0] take;
    for (int i = 0; i < N; i++) busy[i] = |part[i*N +: N];
    for (int j = 0; j < N; j++) begin
      room[j] = CAP;
      for (int i = 0; i < N; i++) if (part[i*N+j]) room[j] = room[j] - 1;
    end
    offer = '0;
    for (int j = 0; j < N; j++)
      for (int s = 0; s < N; s++) begin
        int i;
        i = wrapN(gpM[j] + s);
        if (room[j] > 0 && !busy[i] && req[i*N+j]) begin
          offer[i*N+j] = 1'b1;
          room[j] = room[j] - 1;
        end
      end
    take = '0;
    for (int i = 0; i < N; i++)
      for (int s = 0; s < N; s++) begin
        int j;
        j = wrapN(apM[i] + s);
        if (offer[i*N+j] && (take[i*N +: N] == '0)) take[i*N+j] = 1'b1;
      end
    return part | take;
  endfunction

  task automatic modelReset();
    for (int k = 0; k < IT; k++) mSt[k] = '0;
    for (int k = 0; k < N; k++) begin
      gpM[k] = 0;
      apM[k] = 0;
    end
  endtask

  task automatic stepModel(input logic [N*N-1:0] req);
    logic [N*N-1:0] nxt [IT];
    for (int k = 0; k < IT; k++)
      nxt[k] = refIter(req, (k == 0) ? '0 : (mSt[k-1] & req));
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (nxt[0][i*N+j]) apM[i] = wrapN(j + 1);
    for (int j = 0; j < N; j++) begin
      int last;
      last = -1;
      for (int s = 0; s < N; s++) begin
        int i;
        i = wrapN(gpM[j] + s);
        if (nxt[0][i*N+j]) last = i;
      end
      if (last >= 0) gpM[j] = wrapN(last + 1);
    end
    for (int k = 0; k < IT; k++) mSt[k] = nxt[k];
  endtask

  task automatic checkVec(input string tag, input logic [N*N-1:0] got,
                          input logic [N*N-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic checkInt(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic checkMin(input string tag, input int got, input int lo);
    total++;
    if (got < lo) begin
      bad++;
      $display("FAIL %s got=%0d exp>=%0d", tag, got, lo);
    end
  endtask

  // Drive one slot at the falling edge, sample one edge later
  task automatic tick(input logic [N*N-1:0] req);
    int rowBad, colBad;
    reqMat = req;
    stepModel(req);
    @(posedge clk);
    @(negedge clk);
    rowBad = 0;
    colBad = 0;
    for (int i = 0; i < N; i++) if ($countones(grantMat[i*N +: N]) > 1) rowBad++;
    for (int j = 0; j < N; j++) begin
      int c;
      c = 0;
      for (int i = 0; i < N; i++) c = c + (grantMat[i*N+j] ? 1 : 0);
      if (c > CAP) colBad++;
    end
    checkVec("R1 grant-without-request", grantMat & ~req, '0);
    checkInt("R2 rows-with-two-grants", rowBad, 0);
    checkInt("R3 overfull-outputs", colBad, 0);
    checkVec("R5 model", grantMat, mSt[IT-1]);
  endtask

  task automatic resetDut();
    @(negedge clk);
    rstN   = 1'b0;
    reqMat = '0;
    repeat (2) @(negedge clk);
    modelReset();
    checkVec("R8 reset grants", grantMat, '0);
    rstN = 1'b1;
  endtask

  initial begin
    #1600000;
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int cnt [3];
    rstN   = 1'b0;
    reqMat = '0;
    resetDut();

    // Stimulus table walked by one loop, every slot compared to the model (R5)
    for (int p = 0; p < 8; p++)
      for (int r = 0; r < 5; r++) tick(PATS[p]);

    // R4: lone request from idle pipeline granted after one edge
    resetDut();
    tick(bitAt(2, 5));
    checkVec("R4 single request", grantMat, bitAt(2, 5));
    tick('0);
    checkVec("R6 withdrawn request", grantMat, '0);

    // R7 and R8: pointers start at zero, input accepts lowest output first, then rotates
    resetDut();
    tick(bitAt(0, 1) | bitAt(0, 2));
    checkVec("R8 start pointers", grantMat, bitAt(0, 1));
    tick(bitAt(0, 1) | bitAt(0, 2));
    tick(bitAt(0, 1) | bitAt(0, 2));
    tick(bitAt(0, 1) | bitAt(0, 2));
    checkVec("R7 accept rotation", grantMat, bitAt(0, 2));

    // R3 and R9: three inputs contend for output 3
    resetDut();
    tick(bitAt(0, 3) | bitAt(1, 3) | bitAt(2, 3));
    checkVec("R3 two receivers", grantMat, bitAt(0, 3) | bitAt(1, 3));
    for (int i = 0; i < 3; i++) cnt[i] = grantMat[i*N+3] ? 1 : 0;
    for (int t = 1; t < 30; t++) begin
      tick(bitAt(0, 3) | bitAt(1, 3) | bitAt(2, 3));
      for (int i = 0; i < 3; i++) cnt[i] += grantMat[i*N+3] ? 1 : 0;
    end
    checkMin("R9 input0 share", cnt[0], 8);
    checkMin("R9 input1 share", cnt[1], 8);
    checkMin("R9 input2 share", cnt[2], 8);

    // R6: held pair in flight, then request moves to another output
    resetDut();
    repeat (3) tick(bitAt(4, 6));
    checkVec("R6 held pair", grantMat, bitAt(4, 6));
    tick(bitAt(4, 7));
    checkVec("R6 stale pair dropped", grantMat, bitAt(4, 7));

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule